// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This block takes two IEEE-754 binary operands and returns one of them: the smaller when a minimum is requested, the larger when a maximum is requested. It is purely combinational. There is no clock, no state and no handshake, so the result and the flag follow the operands within the same cycle. It is meant to sit inside a floating-point execute stage, where the surrounding pipeline registers its inputs and outputs.

A mode pin chooses how NaN operands are treated. In propagating mode any NaN operand wins, and operand `a` is checked before operand `b`. In number-preferring mode a quiet NaN gives way to the other operand, while a signalling NaN is still passed through. In both modes negative zero orders strictly below positive zero. A separate flag reports that at least one operand is a signalling NaN.

The exponent and mantissa widths are parameters. Their defaults give single precision.

Top module: `fp_minmax_unit`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its mantissa field is nonzero. A NaN is quiet when the mantissa MSB is 1, which for single precision means all bits of mask 0x7FC00000 are set. Any other NaN is signalling.
- R2: With `op_max`=1 and neither operand a NaN, `result` is the numerically larger operand, compared by sign and then magnitude. Infinities count as ordinary extreme values.
- R3: With `op_max`=0 and neither operand a NaN, `result` is the numerically smaller operand.
- R4: Negative zero (0x80000000) orders strictly below positive zero (0x00000000). Maximum of the two zeros returns +0 and minimum returns -0, whatever the operand order.
- R5: With `num_mode`=0, if `a` is any NaN then `result` equals `a` bit for bit.
- R6: With `num_mode`=0, if `a` is not a NaN and `b` is any NaN, then `result` equals `b`.
- R7: With `num_mode`=1, if `a` is a quiet NaN then `result` equals `b`, whatever `b` holds.
- R8: With `num_mode`=1, if `a` is a signalling NaN then `result` equals `a`.
- R9: With `num_mode`=1 and `a` not a NaN, a quiet NaN `b` yields `a` and a signalling NaN `b` yields `b`.
- R10: `invalid` is 1 exactly when at least one operand is a signalling NaN, in either mode and for either operation.
- R11: `result` is always bit-identical to `a` or to `b`. No NaN is ever made quiet or rewritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 1+EXP_W+MAN_W | First operand, sign/exponent/mantissa from MSB down |
| b | input | 1+EXP_W+MAN_W | Second operand, same layout |
| op_max | input | 1 | 1 selects maximum, 0 selects minimum |
| num_mode | input | 1 | 1 selects number-preferring NaN handling, 0 selects propagating |
| result | output | 1+EXP_W+MAN_W | Selected operand |
| invalid | output | 1 | At least one operand is a signalling NaN |

## Verification
The bench builds the block with its default widths, EXP_W=8 and MAN_W=23, which is single precision. The bench's reference model can therefore use the quiet-NaN mask 0x7FC00000 and an independent integer ordering key. Random operands are drawn from a mix of encodings: signed zeros, infinities, quiet and signalling NaNs, and values that share an exponent. This makes every NaN-priority branch, the signed-zero tie and the magnitude comparison reachable within a few thousand vectors in both modes.

// File: rtl/fp_minmax_pkg.sv
`timescale 1ns/1ps
package fp_minmax_pkg;

  // Classification of one operand.
  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_snan;
    logic is_qnan;
  } fpmm_class_t;

  // Which source drives the result.
  typedef enum logic [1:0] {
    PICK_A   = 2'd0,
    PICK_B   = 2'd1,
    PICK_ORD = 2'd2
  } fpmm_pick_t;

endpackage

// File: rtl/fp_minmax_classify.sv
`timescale 1ns/1ps
module fp_minmax_classify
  import fp_minmax_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] val,
  output fpmm_class_t          cls
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_top;
  logic             man_nz;

  always_comb begin
    exp_f       = val[W-2:MAN_W];
    man_f       = val[MAN_W-1:0];
    exp_top     = &exp_f;
    man_nz      = |man_f;
    cls.sign    = val[W-1];
    cls.is_nan  = exp_top && man_nz;
    cls.is_qnan = exp_top && man_f[MAN_W-1];
    cls.is_snan = exp_top && man_nz && !man_f[MAN_W-1];
  end
endmodule

// File: rtl/fp_minmax_order.sv
`timescale 1ns/1ps
module fp_minmax_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         a_below
);
  logic         sa, sb;
  logic [W-2:0] ma, mb;
  logic         mag_lt, mag_gt;

  always_comb begin
    sa     = a[W-1];
    sb     = b[W-1];
    ma     = a[W-2:0];
    mb     = b[W-2:0];
    mag_lt = ma < mb;
    mag_gt = ma > mb;
    if (sa != sb)
      a_below = sa;          // a negative branch covers -0 below +0
    else if (!sa)
      a_below = mag_lt;
    else
      a_below = mag_gt;
  end
endmodule

// File: rtl/fp_minmax_select.sv
`timescale 1ns/1ps
module fp_minmax_select
  import fp_minmax_pkg::*;
(
  input  fpmm_class_t ca,
  input  fpmm_class_t cb,
  input  logic        num_mode,
  output fpmm_pick_t  pick
);
  always_comb begin
    if (num_mode) begin
      if (ca.is_nan)
        pick = ca.is_snan ? PICK_A : PICK_B;
      else if (cb.is_nan)
        pick = cb.is_snan ? PICK_B : PICK_A;
      else
        pick = PICK_ORD;
    end else begin
      if (ca.is_nan)
        pick = PICK_A;
      else if (cb.is_nan)
        pick = PICK_B;
      else
        pick = PICK_ORD;
    end
  end
endmodule

// File: rtl/fp_minmax_unit.sv
`timescale 1ns/1ps
module fp_minmax_unit
  import fp_minmax_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  input  logic                 op_max,
  input  logic                 num_mode,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 invalid
);
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int N_OPS = 2;

  logic [W-1:0] opnd [N_OPS];
  fpmm_class_t  cls  [N_OPS];
  logic         a_below;
  fpmm_pick_t   pick;
  logic [W-1:0] ordered;

  assign opnd[0] = a;
  assign opnd[1] = b;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fp_minmax_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cls_i (
      .val (opnd[g]),
      .cls (cls[g])
    );
  end

  fp_minmax_order #(.W(W)) ord_i (
    .a       (a),
    .b       (b),
    .a_below (a_below)
  );

  fp_minmax_select sel_i (
    .ca       (cls[0]),
    .cb       (cls[1]),
    .num_mode (num_mode),
    .pick     (pick)
  );

  always_comb begin
    if (op_max)
      ordered = a_below ? b : a;
    else
      ordered = a_below ? a : b;
    unique case (pick)
      PICK_A:  result = a;
      PICK_B:  result = b;
      default: result = ordered;
    endcase
    invalid = cls[0].is_snan | cls[1].is_snan;
  end
endmodule

// File: rtl/fp_minmax_unit_chk.sv
`timescale 1ns/1ps
module fp_minmax_unit_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic [EXP_W+MAN_W:0] a,
  input logic [EXP_W+MAN_W:0] b,
  input logic                 op_max,
  input logic                 num_mode,
  input logic [EXP_W+MAN_W:0] result,
  input logic                 invalid
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] POS_ZERO = '0;
  localparam logic [W-1:0] NEG_ZERO = {1'b1, {(W-1){1'b0}}};

  logic a_nan, b_nan, a_q, b_q, known;

  always_comb begin
    a_nan = (&a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
    b_nan = (&b[W-2:MAN_W]) && (|b[MAN_W-1:0]);
    a_q   = a_nan && a[MAN_W-1];
    b_q   = b_nan && b[MAN_W-1];
    known = !$isunknown({a, b, op_max, num_mode});
    if (known) begin
      AST_RESULT_IS_OPERAND: assert (result == a || result == b); // R11
      AST_PROP_A_NAN: assert (!(!num_mode && a_nan) || result == a); // R5
      AST_PROP_B_NAN: assert (!(!num_mode && !a_nan && b_nan) || result == b); // R6
      AST_NUM_A_QNAN: assert (!(num_mode && a_q) || result == b); // R7
      AST_NUM_A_SNAN: assert (!(num_mode && a_nan && !a_q) || result == a); // R8
      AST_NUM_B_QNAN: assert (!(num_mode && !a_nan && b_q) || result == a); // R9
      AST_ZERO_MAX: assert (!(op_max && ((a == POS_ZERO && b == NEG_ZERO) || (a == NEG_ZERO && b == POS_ZERO))) || result == POS_ZERO); // R4
      AST_ZERO_MIN: assert (!(!op_max && ((a == POS_ZERO && b == NEG_ZERO) || (a == NEG_ZERO && b == POS_ZERO))) || result == NEG_ZERO); // R4
      AST_INVALID_SRC: assert (!invalid || (a_nan && !a_q) || (b_nan && !b_q)); // R10
    end
  end
endmodule

bind fp_minmax_unit fp_minmax_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) chk_i (.*);

// File: tb/fp_minmax_unit_tb_top.sv
`timescale 1ns/1ps
module fp_minmax_unit_tb_top;
  logic        clk = 1'b0;
  logic [31:0] a, b, result;
  logic        op_max, num_mode, invalid;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  fp_minmax_unit dut_i (
    .a(a), .b(b), .op_max(op_max), .num_mode(num_mode),
    .result(result), .invalid(invalid)
  );

  function automatic bit f_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
  endfunction

  function automatic bit f_qnan(input logic [31:0] x);
    return f_nan(x) && ((x & 32'h7FC00000) == 32'h7FC00000);
  endfunction

  function automatic logic [31:0] f_key(input logic [31:0] x);
    return x[31] ? ~x : (x | 32'h80000000);
  endfunction

  function automatic logic [31:0] f_ref(input logic [31:0] x, input logic [31:0] y,
                                        input bit mx, input bit nm);
    bit lt;
    if (nm) begin
      if (f_nan(x)) return f_qnan(x) ? y : x;
      if (f_nan(y)) return f_qnan(y) ? x : y;
    end else begin
      if (f_nan(x)) return x;
      if (f_nan(y)) return y;
    end
    lt = f_key(x) < f_key(y);
    if (mx) return lt ? y : x;
    return lt ? x : y;
  endfunction

  function automatic string f_tag(input logic [31:0] x, input logic [31:0] y,
                                  input bit mx, input bit nm);
    if (!nm && f_nan(x)) return "R5";
    if (!nm && f_nan(y)) return "R6";
    if (nm && f_qnan(x)) return "R7";
    if (nm && f_nan(x)) return "R8";
    if (nm && f_nan(y)) return "R9";
    if ((x[30:0] == 0) && (y[30:0] == 0)) return "R4";
    return mx ? "R2" : "R3";
  endfunction

  task automatic apply_and_check(input logic [31:0] x, input logic [31:0] y,
                                 input bit mx, input bit nm, input string tag);
    logic [31:0] exp_r;
    bit          exp_i;
    @(negedge clk);
    a = x; b = y; op_max = mx; num_mode = nm;
    #2;
    exp_r = f_ref(x, y, mx, nm);
    exp_i = (f_nan(x) && !f_qnan(x)) || (f_nan(y) && !f_qnan(y));
    n_checks++;
    if (result !== exp_r) begin
      n_errors++;
      $display("FAIL %s result a=%h b=%h max=%0d num=%0d: got %h expected %h",
               tag, x, y, mx, nm, result, exp_r);
    end
    n_checks++;
    if (invalid !== exp_i) begin
      n_errors++;
      $display("FAIL R10 invalid (with %s) a=%h b=%h: got %0d expected %0d",
               tag, x, y, invalid, exp_i);
    end
  endtask

  function automatic logic [31:0] f_pick_operand(input int unsigned sel, input int unsigned r);
    case (sel % 9)
      0: return 32'h00000000;
      1: return 32'h80000000;
      2: return {r[0], 8'hFF, 23'd0};                       // infinity
      3: return {r[0], 8'hFF, 1'b1, r[22:1]};               // quiet NaN
      4: return {r[0], 8'hFF, 2'b01, r[21:1]};              // signalling NaN
      5: return {r[0], 8'h7F, r[22:0]};                     // shared exponent
      6: return {r[0], 8'h7F, r[23:1]};
      default: return r;
    endcase
  endfunction

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    a = '0; b = '0; op_max = 1'b0; num_mode = 1'b0;
    repeat (2) @(posedge clk);

    // Directed corner cases
    apply_and_check(32'h3F800000, 32'h40000000, 1'b1, 1'b0, "R2");      // 1.0 vs 2.0 -> 2.0
    apply_and_check(32'hC0000000, 32'hBF800000, 1'b1, 1'b1, "R2");      // -2 vs -1 -> -1
    apply_and_check(32'h7F800000, 32'h7F7FFFFF, 1'b1, 1'b0, "R2");      // +inf larger
    apply_and_check(32'h3F800000, 32'h40000000, 1'b0, 1'b0, "R3");
    apply_and_check(32'hFF800000, 32'hC0000000, 1'b0, 1'b1, "R3");      // -inf smaller
    apply_and_check(32'h80000000, 32'h00000000, 1'b1, 1'b0, "R4");
    apply_and_check(32'h00000000, 32'h80000000, 1'b1, 1'b1, "R4");
    apply_and_check(32'h00000000, 32'h80000000, 1'b0, 1'b0, "R4");
    apply_and_check(32'h80000000, 32'h00000000, 1'b0, 1'b1, "R4");
    apply_and_check(32'h7FC00001, 32'h3F800000, 1'b1, 1'b0, "R5");      // quiet a wins
    apply_and_check(32'hFF800001, 32'h7FC00000, 1'b0, 1'b0, "R5");      // signalling a over NaN b
    apply_and_check(32'h3F800000, 32'h7F800005, 1'b1, 1'b0, "R6");
    apply_and_check(32'h7FC00000, 32'h40400000, 1'b0, 1'b1, "R7");
    apply_and_check(32'hFFC12345, 32'h7F800001, 1'b1, 1'b1, "R7");      // qNaN a yields sNaN b
    apply_and_check(32'h7F800001, 32'h40400000, 1'b1, 1'b1, "R8");
    apply_and_check(32'h40400000, 32'hFFC00000, 1'b0, 1'b1, "R9");
    apply_and_check(32'h40400000, 32'h7FA00000, 1'b1, 1'b1, "R9");
    apply_and_check(32'h7FBFFFFF, 32'h7FC00000, 1'b1, 1'b0, "R1");      // mantissa MSB clear: signalling
    apply_and_check(32'h7F800000, 32'hFF800000, 1'b0, 1'b1, "R1");      // infinities are not NaN

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] x, y;
      bit          mx, nm;
      x  = f_pick_operand($urandom, $urandom);
      y  = f_pick_operand($urandom, $urandom);
      mx = $urandom % 2;
      nm = $urandom % 2;
      apply_and_check(x, y, mx, nm, f_tag(x, y, mx, nm));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog (all requirements): got hung run expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule